// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block is the processor-facing register file of a 16550-style serial port. A host reaches it through a 3-bit offset with separate read and write enables. The block stores the interrupt enables, the line and modem controls, the FIFO control byte, a scratch byte and a 16-bit baud divisor. It drives these values to the serial engine that sits beside it. Receive data, line status, modem status and four raw interrupt requests come in from that engine. The block returns them on reads and turns the requests into an identification code and one gated interrupt line.

Bit 7 of the line control register selects a second bank at offsets 0 and 1. Offset 2 is split by direction: a read returns the identification code and a write loads the FIFO control byte. A receive-buffer read gives the engine a one-cycle pop strobe. A transmit-buffer write gives it a one-cycle push strobe with the data byte.

The offset decoder maps offset and bank bit to one register select: SEL_RXTX, SEL_IER, SEL_IIR_FCR, SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR, SEL_DLL or SEL_DLM. Register writes take effect at the next rising clock edge. Read data and strobes are combinational from the current select.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the interrupt enable, line control, modem control, FIFO control and scratch registers are 0. The stored divisor is 1. A read of offset 2 returns 0x01.
- R2: With line control bit 7 at 0, a read of offset 0 returns `rx_data` and asserts `rx_pop` for that cycle. A write of offset 0 asserts `tx_push` for that cycle, with `tx_data` equal to `wdata`.
- R3: With line control bit 7 at 0, offset 1 is the interrupt enable register. Its 4 low bits are stored and its upper bits read as 0.
- R4: With line control bit 7 at 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Neither strobe fires in this bank.
- R5: Offset 2 reads the identification code and writes the FIFO control byte (`fifo_ctrl`), whatever bit 7 is. Identification bits 7:6 read 11 when FIFO control bit 0 is 1 and 00 otherwise.
- R6: Offset 3 (line control, 8 bits), offset 4 (modem control, 5 bits, upper bits read 0) and offset 7 (scratch) read back what was written, in both banks.
- R7: Offset 5 reads `line_status` and offset 6 reads `modem_status`. Writes to offsets 5 and 6 change no register and no output.
- R8: `irq_src` and enable bits share positions: bit 0 data ready, bit 1 transmit empty, bit 2 line error, bit 3 modem change. The identification code in bits 3:1 names the highest-priority source that is both raised and enabled: line error 011, then data ready 010, then transmit empty 001, then modem change 000. Bit 0 is 0 when a source is pending and 1 when none is.
- R9: `irq` is 1 only when modem control bit 3 is 1 and at least one enabled source is raised.
- R10: The `divisor` output is never 0. When both stored divisor bytes are 0 it shows 1, while reads still return the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rx_data | input | 8 | Byte at the head of the receive path |
| line_status | input | 8 | Line status from the engine |
| modem_status | input | 8 | Modem status from the engine |
| irq_src | input | 4 | Raw interrupt requests |
| rx_pop | output | 1 | Receive byte consumed |
| tx_push | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Byte offered for transmit |
| divisor | output | 16 | Baud divisor, never zero |
| line_ctrl | output | 8 | Framing controls |
| modem_ctrl | output | 5 | Modem control bits |
| fifo_ctrl | output | 8 | FIFO control byte |
| irq | output | 1 | Gated interrupt |

## Verification
The assertions check four things on every cycle:
- `irq` is never high while the interrupt gate bit is 0, and `divisor` is never zero.
- Strobes appear only on offset-0 accesses in the data bank.
- Line control and scratch hold their values on cycles that do not write them.

The bench's scenarios cover what needs a value to be known:
- which register each offset and bank reaches, and the stored bytes read back;
- the identification code under all sixteen request patterns;
- the FIFO flag in bits 7:6;
- writes to the status offsets being ignored.

// File: rtl/uart_host_regs_pkg.sv
package uart_host_regs_pkg;

    typedef enum logic [3:0] {
        SEL_RXTX,
        SEL_IER,
        SEL_IIR_FCR,
        SEL_LCR,
        SEL_MCR,
        SEL_LSR,
        SEL_MSR,
        SEL_SCR,
        SEL_DLL,
        SEL_DLM
    } reg_sel_e;

    localparam int unsigned SRC_COUNT = 4;
    localparam int unsigned MCR_OUT2  = 3;
    localparam int unsigned LCR_BANK  = 7;

    // Priority rank 0 is the highest. Returns the source bit for a rank.
    function automatic int unsigned rank_source(input int unsigned rank);
        unique case (rank)
            0: return 2;   // line error
            1: return 0;   // data ready
            2: return 1;   // transmit empty
            default: return 3; // modem change
        endcase
    endfunction

    // Three-bit identification code for a rank.
    function automatic logic [2:0] rank_code(input int unsigned rank);
        unique case (rank)
            0: return 3'b011;
            1: return 3'b010;
            2: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/uhr_decode.sv
module uhr_decode
    import uart_host_regs_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic [AW-1:0] addr,
    input  logic          bank_hi,
    output reg_sel_e      sel
);
    always_comb begin
        unique case (addr)
            3'd0: sel = bank_hi ? SEL_DLL : SEL_RXTX;
            3'd1: sel = bank_hi ? SEL_DLM : SEL_IER;
            3'd2: sel = SEL_IIR_FCR;
            3'd3: sel = SEL_LCR;
            3'd4: sel = SEL_MCR;
            3'd5: sel = SEL_LSR;
            3'd6: sel = SEL_MSR;
            default: sel = SEL_SCR;
        endcase
    end
endmodule

// File: rtl/uhr_bank.sv
module uhr_bank
    import uart_host_regs_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned IER_W = 4,
    parameter int unsigned MCR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [IER_W-1:0] ier_q,
    output logic [DW-1:0]    lcr_q,
    output logic [MCR_W-1:0] mcr_q,
    output logic [DW-1:0]    fcr_q,
    output logic [DW-1:0]    scr_q,
    output logic [DW-1:0]    dll_q,
    output logic [DW-1:0]    dlm_q
);
    localparam logic [DW-1:0] DLL_RESET = DW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
            lcr_q <= '0;
            mcr_q <= '0;
            fcr_q <= '0;
            scr_q <= '0;
            dll_q <= DLL_RESET;
            dlm_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_IER:     ier_q <= wdata[IER_W-1:0];
                SEL_IIR_FCR: fcr_q <= wdata;
                SEL_LCR:     lcr_q <= wdata;
                SEL_MCR:     mcr_q <= wdata[MCR_W-1:0];
                SEL_SCR:     scr_q <= wdata;
                SEL_DLL:     dll_q <= wdata;
                SEL_DLM:     dlm_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uhr_irq.sv
module uhr_irq
    import uart_host_regs_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [SRC_COUNT-1:0] src,
    input  logic [SRC_COUNT-1:0] enable,
    input  logic                 fifo_on,
    output logic [DW-1:0]        iir,
    output logic                 pending
);
    logic [SRC_COUNT-1:0] hit;
    logic [SRC_COUNT-1:0] rank_hit;
    logic [2:0]           code;

    assign hit = src & enable;

    for (genvar r = 0; r < SRC_COUNT; r++) begin : g_rank
        assign rank_hit[r] = hit[rank_source(r)];
    end

    always_comb begin
        code = 3'b000;
        for (int r = SRC_COUNT - 1; r >= 0; r--) begin
            if (rank_hit[r]) code = rank_code(r);
        end
    end

    assign pending = |hit;

    always_comb begin
        iir      = '0;
        iir[0]   = ~pending;
        iir[3:1] = pending ? code : 3'b000;
        iir[7:6] = {2{fifo_on}};
    end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_regs_pkg::*;
#(
    parameter int unsigned AW    = 3,
    parameter int unsigned DW    = 8,
    parameter int unsigned MCR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [DW-1:0]        rx_data,
    input  logic [DW-1:0]        line_status,
    input  logic [DW-1:0]        modem_status,
    input  logic [SRC_COUNT-1:0] irq_src,
    output logic                 rx_pop,
    output logic                 tx_push,
    output logic [DW-1:0]        tx_data,
    output logic [2*DW-1:0]      divisor,
    output logic [DW-1:0]        line_ctrl,
    output logic [MCR_W-1:0]     modem_ctrl,
    output logic [DW-1:0]        fifo_ctrl,
    output logic                 irq
);
    localparam int unsigned DIV_W = 2 * DW;

    reg_sel_e               sel;
    logic [SRC_COUNT-1:0]   ier_q;
    logic [DW-1:0]          lcr_q;
    logic [MCR_W-1:0]       mcr_q;
    logic [DW-1:0]          fcr_q;
    logic [DW-1:0]          scr_q;
    logic [DW-1:0]          dll_q;
    logic [DW-1:0]          dlm_q;
    logic [DW-1:0]          iir;
    logic                   pending;
    logic [DIV_W-1:0]       div_raw;

    uhr_decode #(.AW(AW)) u_decode (
        .addr    (addr),
        .bank_hi (lcr_q[LCR_BANK]),
        .sel     (sel)
    );

    uhr_bank #(.DW(DW), .IER_W(SRC_COUNT), .MCR_W(MCR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (wr_en),
        .wdata (wdata),
        .ier_q (ier_q),
        .lcr_q (lcr_q),
        .mcr_q (mcr_q),
        .fcr_q (fcr_q),
        .scr_q (scr_q),
        .dll_q (dll_q),
        .dlm_q (dlm_q)
    );

    uhr_irq #(.DW(DW)) u_irq (
        .src     (irq_src),
        .enable  (ier_q),
        .fifo_on (fcr_q[0]),
        .iir     (iir),
        .pending (pending)
    );

    // Read steering
    always_comb begin
        unique case (sel)
            SEL_RXTX:    rdata = rx_data;
            SEL_IER:     rdata = DW'(ier_q);
            SEL_IIR_FCR: rdata = iir;
            SEL_LCR:     rdata = lcr_q;
            SEL_MCR:     rdata = DW'(mcr_q);
            SEL_LSR:     rdata = line_status;
            SEL_MSR:     rdata = modem_status;
            SEL_SCR:     rdata = scr_q;
            SEL_DLL:     rdata = dll_q;
            SEL_DLM:     rdata = dlm_q;
            default:     rdata = '0;
        endcase
    end

    assign rx_pop  = rd_en && (sel == SEL_RXTX);
    assign tx_push = wr_en && (sel == SEL_RXTX);
    assign tx_data = wdata;

    assign div_raw    = {dlm_q, dll_q};
    assign divisor    = (div_raw == '0) ? DIV_W'(1) : div_raw;
    assign line_ctrl  = lcr_q;
    assign modem_ctrl = mcr_q;
    assign fifo_ctrl  = fcr_q;
    assign irq        = mcr_q[MCR_OUT2] && pending;
endmodule

// File: rtl/uart_host_regs_checker.sv
module uart_host_regs_checker #(
    parameter int unsigned AW    = 3,
    parameter int unsigned DW    = 8,
    parameter int unsigned MCR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rx_pop,
    input logic             tx_push,
    input logic [2*DW-1:0]  divisor,
    input logic [DW-1:0]    line_ctrl,
    input logic [MCR_W-1:0] modem_ctrl,
    input logic             irq,
    input logic [DW-1:0]    scr_q
);
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_ctrl[3] |-> !irq);

    p_div_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        divisor != '0);

    p_push_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (wr_en && addr == '0 && !line_ctrl[7]));

    p_pop_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rd_en && addr == '0 && !line_ctrl[7]));

    p_no_strobe_banked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[7] |-> (!tx_push && !rx_pop));

    p_lcr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd3) |=> $stable(line_ctrl));

    p_scratch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd7) |=> $stable(scr_q));
endmodule

bind uart_host_regs uart_host_regs_checker #(.AW(AW), .DW(DW), .MCR_W(MCR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push),
    .divisor    (divisor),
    .line_ctrl  (line_ctrl),
    .modem_ctrl (modem_ctrl),
    .irq        (irq),
    .scr_q      (scr_q)
);

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = 8'hA5;
    logic [7:0]  line_status = 8'h60;
    logic [7:0]  modem_status = 8'h3C;
    logic [3:0]  irq_src = '0;
    logic        rx_pop, tx_push, irq;
    logic [7:0]  tx_data, line_ctrl, fifo_ctrl;
    logic [15:0] divisor;
    logic [4:0]  modem_ctrl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference state
    int m_ier, m_lcr, m_mcr, m_fcr, m_scr, m_dll, m_dlm;

    always #(PERIOD/2) clk = ~clk;

    uart_host_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
        .line_status(line_status), .modem_status(modem_status),
        .irq_src(irq_src), .rx_pop(rx_pop), .tx_push(tx_push),
        .tx_data(tx_data), .divisor(divisor), .line_ctrl(line_ctrl),
        .modem_ctrl(modem_ctrl), .fifo_ctrl(fifo_ctrl), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_iir();
        int v;
        int hit = int'(irq_src) & m_ier;
        if (hit[2])      v = 'h06;
        else if (hit[0]) v = 'h04;
        else if (hit[1]) v = 'h02;
        else if (hit[3]) v = 'h00;
        else             v = 'h01;
        if (m_fcr[0]) v = v | 'hC0;
        return v;
    endfunction

    function automatic int exp_read(input int a);
        bit bank = m_lcr[7];
        case (a)
            0: return bank ? m_dll : int'(rx_data);
            1: return bank ? m_dlm : m_ier;
            2: return exp_iir();
            3: return m_lcr;
            4: return m_mcr;
            5: return int'(line_status);
            6: return int'(modem_status);
            default: return m_scr;
        endcase
    endfunction

    // Compare every output against the model, then advance one clock.
    task automatic step(input bit we, input bit re, input int a, input int d);
        int div_exp;
        bit data_bank;
        addr  = a[2:0];
        wr_en = we;
        rd_en = re;
        wdata = d[7:0];
        #1;
        data_bank = !m_lcr[7];
        div_exp = (m_dlm * 256) + m_dll;
        if (div_exp == 0) div_exp = 1;
        if (re) check(rdata == exp_read(a)[7:0], "R2/R3/R4/R5/R6/R7 read", rdata, exp_read(a));
        check(rx_pop == (re && a == 0 && data_bank), "R2 rx_pop", rx_pop, re && a == 0 && data_bank);
        check(tx_push == (we && a == 0 && data_bank), "R2 tx_push", tx_push, we && a == 0 && data_bank);
        if (tx_push) check(tx_data == d[7:0], "R2 tx_data", tx_data, d);
        check(divisor == div_exp[15:0], "R10 divisor", divisor, div_exp);
        check(line_ctrl == m_lcr[7:0], "R6 line_ctrl", line_ctrl, m_lcr);
        check(modem_ctrl == m_mcr[4:0], "R6 modem_ctrl", modem_ctrl, m_mcr);
        check(fifo_ctrl == m_fcr[7:0], "R5 fifo_ctrl", fifo_ctrl, m_fcr);
        check(irq == (m_mcr[3] && ((int'(irq_src) & m_ier) != 0)), "R9 irq", irq,
              m_mcr[3] && ((int'(irq_src) & m_ier) != 0));
        @(posedge clk);
        if (we) begin
            case (a)
                0: if (!data_bank) m_dll = d & 'hFF;
                1: if (!data_bank) m_dlm = d & 'hFF; else m_ier = d & 'hF;
                2: m_fcr = d & 'hFF;
                3: m_lcr = d & 'hFF;
                4: m_mcr = d & 'h1F;
                7: m_scr = d & 'hFF;
                default: ;
            endcase
        end
        @(negedge clk);
        addr = '0; wr_en = 0; rd_en = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_ier = 0; m_lcr = 0; m_mcr = 0; m_fcr = 0; m_scr = 0; m_dll = 1; m_dlm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        check(divisor == 16'd1, "R1 reset divisor", divisor, 1);
        check(line_ctrl == 8'h00 && modem_ctrl == 5'h00 && fifo_ctrl == 8'h00, "R1 reset ctrl", line_ctrl, 0);
        step(0, 1, 2, 0);            // R1 IIR reads 0x01
        step(0, 1, 7, 0);            // R1 scratch is 0
        step(0, 1, 1, 0);            // R1 enables are 0

        // R2 data bank strobes
        rx_data = 8'h5E;
        step(0, 1, 0, 0);
        step(1, 0, 0, 'hC3);

        // R3 enable register, upper bits read 0
        step(1, 0, 1, 'hFF);
        step(0, 1, 1, 0);

        // R6 line control, modem control, scratch
        step(1, 0, 3, 'h1B);
        step(0, 1, 3, 0);
        step(1, 0, 4, 'hFF);
        step(0, 1, 4, 0);
        step(1, 0, 7, 'h9D);
        step(0, 1, 7, 0);

        // R8 / R9 every request pattern with all enabled and gate on
        for (int s = 0; s < 16; s++) begin
            irq_src = s[3:0];
            step(0, 1, 2, 0);
        end
        // R8 partial enables
        step(1, 0, 1, 'h0A);
        for (int s = 0; s < 16; s++) begin
            irq_src = s[3:0];
            step(0, 1, 2, 0);
        end
        // R9 gate off
        step(1, 0, 4, 'h07);
        irq_src = 4'hF;
        step(0, 1, 2, 0);
        step(1, 0, 4, 'h08);
        step(0, 0, 0, 0);

        // R5 FIFO control and flag
        step(1, 0, 2, 'h01);
        step(0, 1, 2, 0);
        irq_src = 4'h0;
        step(0, 1, 2, 0);

        // R7 status reads, writes ignored
        line_status = 8'h21; modem_status = 8'hB0;
        step(0, 1, 5, 0);
        step(1, 0, 5, 'hFF);
        step(0, 1, 5, 0);
        step(1, 0, 6, 'h00);
        step(0, 1, 6, 0);
        step(0, 1, 7, 0);

        // R4 divisor bank
        step(1, 0, 3, 'h83);
        step(1, 0, 0, 'h34);
        step(1, 0, 1, 'h12);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        // R5 / R6 in the high bank
        step(1, 0, 2, 'h00);
        step(0, 1, 2, 0);
        step(1, 0, 7, 'h42);
        step(0, 1, 7, 0);
        step(0, 1, 3, 0);
        // R10 zero divisor shows 1, reads return stored 0
        step(1, 0, 0, 'h00);
        step(1, 0, 1, 'h00);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        // R4 max divisor
        step(1, 0, 0, 'hFF);
        step(1, 0, 1, 'hFF);
        // back to data bank, enables untouched by divisor writes
        step(1, 0, 3, 'h03);
        step(0, 1, 1, 0);
        step(0, 1, 0, 0);
        step(1, 0, 0, 'h77);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule